// File: doc/BRIEF.md
# Register-Form ADD Execution Unit

This block executes the register-to-register ADD operation of a fixed-width 32-bit RISC instruction encoding. It takes in one 32-bit instruction word per clock cycle together with a valid strobe. It extracts the opcode and the three register specifiers at their fixed bit positions. When the opcode matches, it adds the contents of two source registers held in an internal file of sixteen 32-bit general registers, and it writes the sum into the destination register on the clock edge. A valid word whose opcode does not match changes no register and raises a one-cycle illegal flag.

A combinational debug port returns the contents of any register. A load port lets the environment seed register values before an instruction stream starts, because registers come out of reset as zero. The load port only acts in cycles with no valid instruction. The block has no condition codes, no immediate or shifted operands, no program counter and no memory access.

Top module: `add_exec_unit`

## Requirements
- R1: While reset is active, and after it is released, every register reads zero on the debug port and `illegal_o` is low.
- R2: A word presented with `instr_valid` high executes as an ADD only when bits 27..23 equal 5'b00001. The sum is committed on that clock edge and is visible on the debug port from the next cycle.
- R3: A valid word whose bits 27..23 differ from 5'b00001 writes no register.
- R4: `illegal_o` is high in the cycle after a valid word with a non-matching opcode. It is low in the cycle after a valid matching word and in the cycle after a cycle with `instr_valid` low.
- R5: The first source index Rn is taken from bits 19..16, the destination index Rd from bits 15..12 and the second source index Rm from bits 3..0. Each is unsigned, and any of the 16 registers can fill any role.
- R6: The sum wraps modulo 2^32, and no carry is kept.
- R7: Sources are read with their values from before the edge, so Rd may equal Rn or Rm. For example, word 0xE0823003 with r2=97 and r3=8 leaves r3=105, and every other register is unchanged.
- R8: Bits 31..28, 22..20 and 11..4 have no effect on the result.
- R9: A cycle with `instr_valid` low and `ld_en` low changes no register.
- R10: With `instr_valid` low and `ld_en` high, register `ld_idx` takes `ld_data` at the edge.
- R11: `ld_en` is ignored in any cycle where `instr_valid` is high.
- R12: `dbg_data` shows the current contents of register `dbg_idx` combinationally, with no clock cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 32 | Instruction word |
| ld_en | input | 1 | Register seed write enable |
| ld_idx | input | 4 | Register seed index |
| ld_data | input | 32 | Register seed value |
| dbg_idx | input | 4 | Debug read index |
| dbg_data | output | 32 | Debug read data |
| illegal_o | output | 1 | Non-matching opcode flag, one cycle |

## Verification
The no-write assertions compare `dbg_data` across two cycles. They assume the environment holds `dbg_idx` still over those cycles, and they only fire when the index is stable. The bench changes `dbg_idx` only while it reads back the register file in idle cycles, so most execute and illegal cycles see a fixed index. The assertions also assume `ld_en` is meaningful only when `instr_valid` is low. The bench deliberately drives both at once to exercise R11, and the no-write checks already cover that case.

// File: rtl/add_exec_pkg.sv
package add_exec_pkg;
    parameter int XLEN    = 32;
    parameter int NREGS   = 16;
    parameter int IDX_W   = $clog2(NREGS);
    parameter int OP_LSB  = 23;
    parameter int OP_W    = 5;
    parameter logic [OP_W-1:0] OP_ADD = 5'b00001;
    parameter int RN_LSB  = 16;
    parameter int RD_LSB  = 12;
    parameter int RM_LSB  = 0;

    typedef struct packed {
        logic             is_add;
        logic [IDX_W-1:0] rn;
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] rm;
    } dec_t;

    typedef struct packed {
        logic             illegal;
    } ctl_t;
endpackage

// File: rtl/aeu_decode.sv
module aeu_decode
    import add_exec_pkg::*;
(
    input  logic [XLEN-1:0] word_i,
    output dec_t            dec_o
);
    always_comb begin
        dec_o        = '0;
        dec_o.is_add = (word_i[OP_LSB +: OP_W] == OP_ADD);
        dec_o.rn     = word_i[RN_LSB +: IDX_W];
        dec_o.rd     = word_i[RD_LSB +: IDX_W];
        dec_o.rm     = word_i[RM_LSB +: IDX_W];
    end
endmodule

// File: rtl/aeu_adder.sv
module aeu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    always_comb begin
        sum_o = a_i + b_i;
    end
endmodule

// File: rtl/aeu_regfile.sv
module aeu_regfile #(
    parameter int W  = 32,
    parameter int N  = 16,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a_i,
    input  logic [AW-1:0] ra_b_i,
    input  logic [AW-1:0] ra_dbg_i,
    output logic [W-1:0]  rd_a_o,
    output logic [W-1:0]  rd_b_o,
    output logic [W-1:0]  rd_dbg_o,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [W-1:0]  wd_i
);
    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    for (genvar g = 0; g < N; g++) begin : g_entry
        always_comb begin
            regs_d[g] = regs_q[g];
            if (we_i && (wa_i == AW'(g))) begin
                regs_d[g] = wd_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    always_comb begin
        rd_a_o   = regs_q[ra_a_i];
        rd_b_o   = regs_q[ra_b_i];
        rd_dbg_o = regs_q[ra_dbg_i];
    end
endmodule

// File: rtl/add_exec_unit.sv
module add_exec_unit
    import add_exec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic [XLEN-1:0]  instr_word,
    input  logic             ld_en,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [XLEN-1:0]  ld_data,
    input  logic [IDX_W-1:0] dbg_idx,
    output logic [XLEN-1:0]  dbg_data,
    output logic             illegal_o
);
    dec_t             dec;
    logic [XLEN-1:0]  src_n;
    logic [XLEN-1:0]  src_m;
    logic [XLEN-1:0]  sum;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [XLEN-1:0]  wr_val;
    ctl_t             ctl_d;
    ctl_t             ctl_q;

    aeu_decode u_dec (
        .word_i (instr_word),
        .dec_o  (dec)
    );

    aeu_regfile #(.W(XLEN), .N(NREGS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_a_i   (dec.rn),
        .ra_b_i   (dec.rm),
        .ra_dbg_i (dbg_idx),
        .rd_a_o   (src_n),
        .rd_b_o   (src_m),
        .rd_dbg_o (dbg_data),
        .we_i     (wr_en),
        .wa_i     (wr_idx),
        .wd_i     (wr_val)
    );

    aeu_adder #(.W(XLEN)) u_add (
        .a_i   (src_n),
        .b_i   (src_m),
        .sum_o (sum)
    );

    // Instruction path owns the write port whenever valid is high.
    always_comb begin
        ctl_d         = '0;
        ctl_d.illegal = instr_valid && !dec.is_add;
        if (instr_valid) begin
            wr_en  = dec.is_add;
            wr_idx = dec.rd;
            wr_val = sum;
        end else begin
            wr_en  = ld_en;
            wr_idx = ld_idx;
            wr_val = ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign illegal_o = ctl_q.illegal;
endmodule

// File: rtl/add_exec_checker.sv
module add_exec_checker
    import add_exec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             instr_valid,
    input logic [XLEN-1:0]  instr_word,
    input logic             ld_en,
    input logic [IDX_W-1:0] dbg_idx,
    input logic [XLEN-1:0]  dbg_data,
    input logic             illegal_o
);
    logic op_hit;
    assign op_hit = (instr_word[OP_LSB +: OP_W] == OP_ADD);

    assert_illegal_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !op_hit) |=> illegal_o);

    assert_illegal_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && !op_hit) |=> !illegal_o);

    assert_nomatch_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(instr_valid && !op_hit) && $stable(dbg_idx)) |-> $stable(dbg_data));

    assert_idle_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!instr_valid && !ld_en) && $stable(dbg_idx)) |-> $stable(dbg_data));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_zero_R1: assert (dbg_data == '0 && !illegal_o);
        end
    end
endmodule

bind add_exec_unit add_exec_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .ld_en       (ld_en),
    .dbg_idx     (dbg_idx),
    .dbg_data    (dbg_data),
    .illegal_o   (illegal_o)
);

// File: tb/tb_add_exec_unit.sv
module tb_add_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [3:0]  dbg_idx = '0;
    logic [31:0] dbg_data;
    logic        illegal_o;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] mdl [16];

    always #4 clk = ~clk;

    add_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data), .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] cnd, input logic [4:0] op,
                                       input logic [3:0] rn, input logic [3:0] rd,
                                       input logic [3:0] rm, input logic [14:0] junk);
        return {cnd, op, junk[14:12], rn, rd, junk[7:0], rm};
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < 16; i++) begin
            dbg_idx = 4'(i);
            #1;
            chk(dbg_data === mdl[i], req, dbg_data, mdl[i]);
        end
        dbg_idx = '0;
    endtask

    task automatic load(input int idx, input logic [31:0] val);
        ld_en = 1'b1; ld_idx = 4'(idx); ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
        mdl[idx] = val;
    endtask

    // drives one word for one cycle; returns illegal flag of the following cycle
    task automatic exec(input logic [31:0] w, input bit with_ld, output logic ill);
        instr_valid = 1'b1; instr_word = w;
        ld_en = with_ld; ld_idx = 4'd15; ld_data = 32'hDEAD_BEEF;
        @(negedge clk);
        ill = illegal_o;
        instr_valid = 1'b0; ld_en = 1'b0;
        if (w[27:23] == 5'b00001) mdl[w[15:12]] = mdl[w[19:16]] + mdl[w[3:0]];
    endtask

    task automatic t_reset;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(illegal_o === 1'b0, "R1 illegal in reset", 32'(illegal_o), 0);
        check_regs("R1 reset value");
        rst_n = 1'b1;
        @(negedge clk);
        check_regs("R1 after release");
    endtask

    task automatic t_load;
        for (int i = 0; i < 16; i++) load(i, 32'h1000 * i + 32'h11);
        check_regs("R10 R12 load and debug read");
    endtask

    task automatic t_example;
        logic ill;
        load(2, 97); load(3, 8);
        exec(32'hE082_3003, 1'b0, ill);
        chk(ill === 1'b0, "R4 matching word no flag", 32'(ill), 0);
        dbg_idx = 4'd3; #1;
        chk(dbg_data === 32'd105, "R7 example r3", dbg_data, 105);
        check_regs("R7 R2 others unchanged");
    endtask

    task automatic t_fields;
        logic ill;
        for (int k = 0; k < 16; k++) begin
            exec(mk(4'hE, 5'b00001, 4'(k), 4'(15 - k), 4'((k * 7) % 16), '0), 1'b0, ill);
        end
        check_regs("R5 field positions sweep");
    endtask

    task automatic t_wrap;
        logic ill;
        load(5, 32'hFFFF_FFF0); load(6, 32'h0000_0025);
        exec(mk(4'hE, 5'b00001, 4'd5, 4'd7, 4'd6, '0), 1'b0, ill);
        dbg_idx = 4'd7; #1;
        chk(dbg_data === 32'h15, "R6 wrap", dbg_data, 32'h15);
        load(8, 32'h8000_0000);
        exec(mk(4'h0, 5'b00001, 4'd8, 4'd8, 4'd8, '0), 1'b0, ill);
        dbg_idx = 4'd8; #1;
        chk(dbg_data === 32'h0, "R6 R7 self double wrap", dbg_data, 0);
    endtask

    task automatic t_illegal;
        logic ill;
        logic [4:0] ops [4] = '{5'b00000, 5'b00011, 5'b10001, 5'b11111};
        foreach (ops[j]) begin
            exec(mk(4'hE, ops[j], 4'd1, 4'd2, 4'd3, 15'h5A5A), 1'b1, ill);
            chk(ill === 1'b1, "R4 flag after bad opcode", 32'(ill), 1);
            check_regs("R3 R11 no write on bad opcode");
        end
        @(negedge clk);
        chk(illegal_o === 1'b0, "R4 flag single cycle", 32'(illegal_o), 0);
    endtask

    task automatic t_ignored;
        logic ill;
        load(9, 32'h0000_0100); load(10, 32'h0000_0023);
        exec(mk(4'h3, 5'b00001, 4'd9, 4'd11, 4'd10, 15'h7FFF), 1'b0, ill);
        dbg_idx = 4'd11; #1;
        chk(dbg_data === 32'h123, "R8 ignored bits set", dbg_data, 32'h123);
        exec(mk(4'hF, 5'b00001, 4'd11, 4'd12, 4'd9, 15'h2A55), 1'b0, ill);
        dbg_idx = 4'd12; #1;
        chk(dbg_data === 32'h223, "R8 other cond value", dbg_data, 32'h223);
    endtask

    task automatic t_idle;
        instr_word = mk(4'hE, 5'b00001, 4'd1, 4'd1, 4'd1, '0);
        ld_idx = 4'd1; ld_data = 32'hCAFE_0000;
        repeat (3) @(negedge clk);
        chk(illegal_o === 1'b0, "R4 no flag when idle", 32'(illegal_o), 0);
        check_regs("R9 idle no write");
    endtask

    task automatic t_blocked_load;
        logic ill;
        exec(mk(4'hE, 5'b00001, 4'd2, 4'd4, 4'd3, '0), 1'b1, ill);
        check_regs("R11 load ignored during add");
    endtask

    initial begin
        t_reset();
        t_load();
        t_example();
        t_fields();
        t_wrap();
        t_illegal();
        t_ignored();
        t_idle();
        t_blocked_load();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule